// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers a bank of interrupt request lines and steers each of them to one or more parent interrupt outputs and to the status view of one or more processor cores. Every line owns a one-byte route entry. The upper nibble of that byte picks parent outputs and the lower nibble picks cores. A line can be set up as level-high, level-low, rising-edge or falling-edge. A line counts as pending only while its enable bit is set.

Software programs the block over a simple synchronous register bus. A write takes effect at the rising clock edge while `bus_we` is high. Read data is a combinational function of `bus_addr` and `bus_core`. Enables are changed through a set register and a clear register, so lines can be switched on or off without a read-modify-write. The pending word read back depends on which core is asking, given on `bus_core`. Edge events are held in a sticky latch until software acknowledges them. The request inputs are assumed to be already synchronous to `clk`.

Top module: `route_intc`

## Requirements
- R1: After reset, the following are all zero: every enable bit, polarity bit and edge-mode bit, every route byte, every edge latch, and `parent_irq`.
- R2: The route byte for line i sits at byte address i (0x00..0x1F), in byte lane i mod 4 of the word at address 4*(i/4). A write changes only the lanes whose `bus_be` bit is 1. Bits 7:4 of the byte select parent outputs 0..3 and bits 3:0 select cores 0..3. The word reads back at the same address.
- R3: Writing word address 0x28 sets the enable bits written as 1. Writing word address 0x2C clears the enable bits written as 1. Bits written as 0 are unchanged, so 0xFFFFFFFF at 0x2C disables every line in one write. The enable mask reads at 0x24. An enable change takes effect from the next clock.
- R4: The polarity register is at 0x30 and the edge-mode register at 0x34. With edge bit 0, a line is level-triggered: it is active when its input equals its polarity bit (1 = high, 0 = low). Its pending bit is enable AND active, combinationally. Writing 0 to 0x34 makes every line level-triggered.
- R5: With edge bit 1, polarity 1 selects rising edges and polarity 0 selects falling edges. The input is compared with its value at the previous clock. A detected edge on an enabled line sets a sticky latch, which is visible from the clock that sampled the edge. The pending bit of an edge-mode line is enable AND latch.
- R6: An edge latch is cleared by writing 1 to its bit at word address 0x40, or by writing 1 to its bit at 0x2C.
- R7: Parent output n is high when any pending line has route bit 4+n set. A line with several parent bits set drives all of those outputs.
- R8: A pending line whose route byte has bits 7:4 all zero never raises any parent output.
- R9: A read of 0x40 returns the pending lines whose route byte has bit `bus_core` set. All other bits read as 0.
- R10: When an edge is detected in the same clock as a write of 1 to that line's bit at 0x40, the latch stays set.
- R11: An edge that arrives while its line is disabled is not recorded, even if the line is enabled afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored except as lane position |
| bus_be | input | 4 | Byte lane enables, used by route words only |
| bus_wdata | input | 32 | Write data |
| bus_core | input | 2 | Index of the core whose status view is read |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| parent_irq | output | 4 | Parent interrupt outputs |

## Verification
The cases hardest to reach from the ports involve a bus write and an input transition sampled at the same clock edge. One is a new edge landing in the clock that acknowledges the same line. The other is an edge that arrives while the line is disabled and is followed by an enable. The bench drives the input change and the register write from one task at the same falling edge, so both are sampled together. It then reads the core's status view on the following cycles. A behavioural model is compared with `parent_irq` and `bus_rdata` on every clock, so the multi-parent, no-parent and per-core filtering cases are covered with the different core indexes selected.

// File: rtl/rlic_pkg.sv
// Package: shared constants for the routed local interrupt controller.
// Holds the register word addresses; widths are parameters of the modules.
package rlic_pkg;
    localparam logic [7:0] ADDR_EN_RD  = 8'h24;
    localparam logic [7:0] ADDR_EN_SET = 8'h28;
    localparam logic [7:0] ADDR_EN_CLR = 8'h2C;
    localparam logic [7:0] ADDR_POL    = 8'h30;
    localparam logic [7:0] ADDR_MODE   = 8'h34;
    localparam logic [7:0] ADDR_STAT   = 8'h40;
    localparam int         ROUTE_BITS  = 8;
    localparam int         PAR_LSB     = 4;
endpackage

// File: rtl/rlic_regs.sv
// Register file: route bytes, enable (set/clear), polarity, edge mode and
// the read mux. Assumes DW == 32, NL <= DW and an 8-bit route byte per line.
// Emits one-cycle disable and acknowledge masks decoded from bus writes.
module rlic_regs #(
    parameter int NL = 32,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_we,
    input  logic [AW-1:0]                  bus_addr,
    input  logic [DW/8-1:0]                bus_be,
    input  logic [DW-1:0]                  bus_wdata,
    input  logic [NL-1:0]                  stat_word,
    output logic [NL*rlic_pkg::ROUTE_BITS-1:0] route_flat,
    output logic [NL-1:0]                  en_q,
    output logic [NL-1:0]                  pol_q,
    output logic [NL-1:0]                  edge_q,
    output logic [NL-1:0]                  dis_bits,
    output logic [NL-1:0]                  w1c_bits,
    output logic [DW-1:0]                  bus_rdata
);
    localparam int LANES  = DW / 8;
    localparam int LW     = $clog2(LANES);
    localparam int RWORDS = NL / LANES;
    localparam int IW     = AW - LW;
    localparam logic [IW-1:0] RWORDS_W = IW'(RWORDS);

    logic [AW-1:0] waddr;
    logic [IW-1:0] word_idx;
    logic          in_route;
    logic [NL-1:0] set_bits;
    logic          wr_pol;
    logic          wr_mode;

    // Word-aligned address and route-region decode.
    always_comb begin
        word_idx = bus_addr[AW-1:LW];
        waddr    = {word_idx, {LW{1'b0}}};
        in_route = (word_idx < RWORDS_W);
    end

    // One-cycle write masks for the set/clear/acknowledge registers.
    always_comb begin
        set_bits = (bus_we && waddr == AW'(rlic_pkg::ADDR_EN_SET)) ? bus_wdata[NL-1:0] : '0;
        dis_bits = (bus_we && waddr == AW'(rlic_pkg::ADDR_EN_CLR)) ? bus_wdata[NL-1:0] : '0;
        w1c_bits = (bus_we && waddr == AW'(rlic_pkg::ADDR_STAT))   ? bus_wdata[NL-1:0] : '0;
        wr_pol   = bus_we && waddr == AW'(rlic_pkg::ADDR_POL);
        wr_mode  = bus_we && waddr == AW'(rlic_pkg::ADDR_MODE);
    end

    // Route byte per line, written through its own byte lane.
    for (genvar i = 0; i < NL; i++) begin : g_route
        localparam int WI = i / LANES;
        localparam int LI = i % LANES;
        logic [rlic_pkg::ROUTE_BITS-1:0] rbyte;

        // Capture the lane when the owning word is written with its lane enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rbyte <= '0;
            else if (bus_we && in_route && word_idx == IW'(WI) && bus_be[LI])
                rbyte <= bus_wdata[LI*8 +: 8];
        end
        assign route_flat[i*rlic_pkg::ROUTE_BITS +: rlic_pkg::ROUTE_BITS] = rbyte;
    end

    // Enable mask: set bits, then clear bits, zeros leave lines alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else
            en_q <= (en_q | set_bits) & ~dis_bits;
    end

    // Polarity and edge-mode registers, full-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edge_q <= '0;
        end else begin
            if (wr_pol)  pol_q  <= bus_wdata[NL-1:0];
            if (wr_mode) edge_q <= bus_wdata[NL-1:0];
        end
    end

    // Read mux: route words, enable, polarity, mode, per-core status.
    always_comb begin
        bus_rdata = '0;
        if (in_route) begin
            bus_rdata = route_flat[int'(word_idx)*DW +: DW];
        end else begin
            case (waddr)
                AW'(rlic_pkg::ADDR_EN_RD): bus_rdata[NL-1:0] = en_q;
                AW'(rlic_pkg::ADDR_POL):   bus_rdata[NL-1:0] = pol_q;
                AW'(rlic_pkg::ADDR_MODE):  bus_rdata[NL-1:0] = edge_q;
                AW'(rlic_pkg::ADDR_STAT):  bus_rdata[NL-1:0] = stat_word;
                default:                   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/rlic_trigger.sv
// Trigger conditioning: per line, level compare or edge detect with a
// sticky latch. Assumes irq_in is already synchronous to clk. An edge that
// coincides with an acknowledge wins; a disable write always clears.
module rlic_trigger #(
    parameter int NL = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] irq_in,
    input  logic [NL-1:0] en_q,
    input  logic [NL-1:0] pol_q,
    input  logic [NL-1:0] edge_q,
    input  logic [NL-1:0] dis_bits,
    input  logic [NL-1:0] w1c_bits,
    output logic [NL-1:0] latch_q,
    output logic [NL-1:0] pend
);
    for (genvar i = 0; i < NL; i++) begin : g_line
        logic in_q;
        logic lat;
        logic hit;
        logic lvl_act;
        logic lat_d;

        // Edge and level conditions for this line.
        always_comb begin
            hit     = pol_q[i] ? (irq_in[i] & ~in_q) : (~irq_in[i] & in_q);
            lvl_act = ~(irq_in[i] ^ pol_q[i]);
            lat_d   = edge_q[i] & en_q[i] & ~dis_bits[i] & (hit | (lat & ~w1c_bits[i]));
        end

        // Previous input sample and sticky edge latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_q <= 1'b0;
                lat  <= 1'b0;
            end else begin
                in_q <= irq_in[i];
                lat  <= lat_d;
            end
        end

        assign latch_q[i] = lat;
        assign pend[i]    = en_q[i] & (edge_q[i] ? lat : lvl_act);
    end
endmodule

// File: rtl/rlic_route.sv
// Routing: OR of pending lines per parent output, and the pending word
// filtered by the core bit of each route byte. Purely combinational.
module rlic_route #(
    parameter int NL = 32,
    parameter int NP = 4,
    parameter int NC = 4,
    parameter int CW = 2
) (
    input  logic [NL*rlic_pkg::ROUTE_BITS-1:0] route_flat,
    input  logic [NL-1:0]                      pend,
    input  logic [CW-1:0]                      core_sel,
    output logic [NP-1:0]                      parent_irq,
    output logic [NL-1:0]                      stat_word
);
    logic [NL-1:0] pmask [NP];
    logic [NL-1:0] cmask [NC];

    // Gather each route byte's parent bits into per-output masks.
    for (genvar n = 0; n < NP; n++) begin : g_par
        for (genvar i = 0; i < NL; i++) begin : g_bit
            assign pmask[n][i] = route_flat[i*rlic_pkg::ROUTE_BITS + rlic_pkg::PAR_LSB + n];
        end
        assign parent_irq[n] = |(pend & pmask[n]);
    end

    // Gather each route byte's core bits into per-core masks.
    for (genvar c = 0; c < NC; c++) begin : g_core
        for (genvar i = 0; i < NL; i++) begin : g_bit
            assign cmask[c][i] = route_flat[i*rlic_pkg::ROUTE_BITS + c];
        end
    end

    // Status view of the requesting core.
    always_comb begin
        stat_word = '0;
        for (int c = 0; c < NC; c++)
            if (core_sel == CW'(c)) stat_word = pend & cmask[c];
    end
endmodule

// File: rtl/route_intc.sv
// Top: routed local interrupt controller. Ties register file, trigger
// conditioning and routing together. Assumes synchronous inputs and a
// single-cycle register bus with combinational read data.
module route_intc #(
    parameter int NL = 32,
    parameter int NP = 4,
    parameter int NC = 4,
    parameter int AW = 8,
    parameter int DW = 32,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] irq_in,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW/8-1:0] bus_be,
    input  logic [DW-1:0] bus_wdata,
    input  logic [CW-1:0] bus_core,
    output logic [DW-1:0] bus_rdata,
    output logic [NP-1:0] parent_irq
);
    logic [NL*rlic_pkg::ROUTE_BITS-1:0] route_flat;
    logic [NL-1:0] en_q;
    logic [NL-1:0] pol_q;
    logic [NL-1:0] edge_q;
    logic [NL-1:0] dis_bits;
    logic [NL-1:0] w1c_bits;
    logic [NL-1:0] latch_q;
    logic [NL-1:0] pend;
    logic [NL-1:0] stat_word;

    rlic_regs #(.NL(NL), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .stat_word(stat_word),
        .route_flat(route_flat), .en_q(en_q), .pol_q(pol_q), .edge_q(edge_q),
        .dis_bits(dis_bits), .w1c_bits(w1c_bits), .bus_rdata(bus_rdata)
    );

    rlic_trigger #(.NL(NL)) u_trig (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en_q(en_q), .pol_q(pol_q),
        .edge_q(edge_q), .dis_bits(dis_bits), .w1c_bits(w1c_bits),
        .latch_q(latch_q), .pend(pend)
    );

    rlic_route #(.NL(NL), .NP(NP), .NC(NC), .CW(CW)) u_route (
        .route_flat(route_flat), .pend(pend), .core_sel(bus_core),
        .parent_irq(parent_irq), .stat_word(stat_word)
    );
endmodule

// File: rtl/rlic_checker.sv
// Checker: temporal properties of the controller, bound to route_intc.
// Observes bus writes, enable and latch state, pending lines and outputs.
module rlic_checker #(
    parameter int NL = 32,
    parameter int NP = 4,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [NL-1:0] en_q,
    input logic [NL-1:0] edge_q,
    input logic [NL-1:0] latch_q,
    input logic [NL-1:0] dis_bits,
    input logic [NL-1:0] w1c_bits,
    input logic [NL-1:0] pend,
    input logic [NP-1:0] parent_irq
);
    logic [AW-1:0] waddr;
    logic          wr_set;
    logic          wr_clr;
    logic [NL-1:0] keep;

    // Independent decode of the bus for the checks.
    always_comb begin
        waddr  = {bus_addr[AW-1:2], 2'b00};
        wr_set = bus_we && waddr == AW'(8'h28);
        wr_clr = bus_we && waddr == AW'(8'h2C);
        keep   = latch_q & edge_q & en_q & ~dis_bits & ~w1c_bits;
    end

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_q == '0 && latch_q == '0 && parent_irq == '0));

    assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en_q & $past(bus_wdata[NL-1:0])) == $past(bus_wdata[NL-1:0])));

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en_q & $past(bus_wdata[NL-1:0])) == '0));

    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(en_q));

    assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (keep != '0) |=> ((latch_q & $past(keep)) == $past(keep)));

    assert_latch_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & ~$past(latch_q) & ~$past(edge_q & en_q)) == '0);

    assert_dis_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((latch_q & $past(bus_wdata[NL-1:0])) == '0));

    assert_parent_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (parent_irq == '0));
endmodule

bind route_intc rlic_checker #(.NL(NL), .NP(NP), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .edge_q(edge_q), .latch_q(latch_q),
    .dis_bits(dis_bits), .w1c_bits(w1c_bits), .pend(pend), .parent_irq(parent_irq)
);

// File: tb/tb_route_intc.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks per requirement.
module tb_route_intc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_core = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  parent_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state.
    bit [31:0] m_en, m_pol, m_edge, m_lat, m_inq;
    bit [7:0]  m_route [32];

    route_intc dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_core(bus_core), .bus_rdata(bus_rdata), .parent_irq(parent_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [31:0] m_pend();
        bit [31:0] p;
        for (int i = 0; i < 32; i++) begin
            bit act;
            act = m_edge[i] ? m_lat[i] : (irq_in[i] == m_pol[i]);
            p[i] = m_en[i] && act;
        end
        return p;
    endfunction

    function automatic bit [3:0] m_parent();
        bit [3:0] r = '0;
        bit [31:0] p = m_pend();
        for (int i = 0; i < 32; i++)
            if (p[i]) r = r | m_route[i][7:4];
        return r;
    endfunction

    function automatic bit [31:0] m_read(input bit [7:0] a, input bit [1:0] core);
        bit [7:0] w = {a[7:2], 2'b00};
        bit [31:0] p = m_pend();
        bit [31:0] s = '0;
        if (w < 8'h20) return {m_route[w+3], m_route[w+2], m_route[w+1], m_route[w]};
        case (w)
            8'h24: return m_en;
            8'h30: return m_pol;
            8'h34: return m_edge;
            8'h40: begin
                for (int i = 0; i < 32; i++) s[i] = p[i] && m_route[i][core];
                return s;
            end
            default: return '0;
        endcase
    endfunction

    // Model update at each rising edge from the inputs driven at the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_pol = '0; m_edge = '0; m_lat = '0; m_inq = '0;
            for (int i = 0; i < 32; i++) m_route[i] = '0;
        end else begin
            bit [7:0] w;
            bit [31:0] nl;
            w = {bus_addr[7:2], 2'b00};
            for (int i = 0; i < 32; i++) begin
                bit hit, dis, ack;
                hit = m_pol[i] ? (irq_in[i] && !m_inq[i]) : (!irq_in[i] && m_inq[i]);
                dis = bus_we && w == 8'h2C && bus_wdata[i];
                ack = bus_we && w == 8'h40 && bus_wdata[i];
                nl[i] = m_edge[i] && m_en[i] && !dis && (hit || (m_lat[i] && !ack));
            end
            if (bus_we) begin
                if (w < 8'h20) begin
                    for (int k = 0; k < 4; k++)
                        if (bus_be[k]) m_route[w+k] = bus_wdata[8*k +: 8];
                end
                if (w == 8'h28) m_en = m_en | bus_wdata;
                if (w == 8'h2C) m_en = m_en & ~bus_wdata;
                if (w == 8'h30) m_pol = bus_wdata;
                if (w == 8'h34) m_edge = bus_wdata;
            end
            m_inq = irq_in;
            m_lat = nl;
        end
    end

    // Per-clock comparison against the model (R7 parents, R9 reads).
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            checks++;
            if (parent_irq !== m_parent()) begin
                failures++;
                $display("FAIL R7 model parent_irq actual=%h expected=%h", parent_irq, m_parent());
            end
            checks++;
            if (bus_rdata !== m_read(bus_addr, bus_core)) begin
                failures++;
                $display("FAIL R9 model read addr=%h actual=%h expected=%h",
                         bus_addr, bus_rdata, m_read(bus_addr, bus_core));
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic set_in(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] core, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_core = core;
        #2;
        check(tag, bus_rdata, exp);
    endtask

    task automatic chk_par(input logic [3:0] exp, input string tag);
        @(negedge clk);
        #2;
        check(tag, {28'd0, parent_irq}, {28'd0, exp});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h24, 2'd0, 32'h0, "R1 enable after reset");
        rd(8'h30, 2'd0, 32'h0, "R1 polarity after reset");
        rd(8'h34, 2'd0, 32'h0, "R1 mode after reset");
        rd(8'h1C, 2'd0, 32'h0, "R1 route after reset");
        rd(8'h40, 2'd0, 32'h0, "R1 status after reset");
        chk_par(4'h0, "R1 parent after reset");

        // R2: byte-lane route writes
        wr(8'h00, 32'h2412_1811, 4'b0101);
        rd(8'h00, 2'd0, 32'h0012_0011, "R2 route lanes 0 and 2 only");

        // R3: set/clear enables
        wr(8'h28, 32'h0000_00F0);
        rd(8'h24, 2'd0, 32'h0000_00F0, "R3 set");
        wr(8'h28, 32'h0000_000F);
        rd(8'h24, 2'd0, 32'h0000_00FF, "R3 zeros unchanged on set");
        wr(8'h2C, 32'h0000_0030);
        rd(8'h24, 2'd0, 32'h0000_00CF, "R3 clear");
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h24, 2'd0, 32'h0, "R3 disable all");

        // R4: level triggering, line0 high (route 0x11), line2 low (route 0x12)
        wr(8'h30, 32'h0000_0001);
        wr(8'h34, 32'h0);
        rd(8'h34, 2'd0, 32'h0, "R4 all level");
        wr(8'h28, 32'h0000_0005);
        rd(8'h40, 2'd1, 32'h0000_0004, "R4 level-low active");
        rd(8'h40, 2'd0, 32'h0, "R4 level-high idle");
        chk_par(4'h1, "R4 parent from level-low");
        set_in(32'h5);
        rd(8'h40, 2'd0, 32'h0000_0001, "R4 level-high active");
        rd(8'h40, 2'd1, 32'h0, "R4 level-low idle");
        set_in(32'h4);
        chk_par(4'h0, "R4 both idle");

        // R5: rising edge on line1 (route 0x22)
        wr(8'h2C, 32'hFFFF_FFFF);
        set_in(32'h0);
        wr(8'h00, 32'h0000_2200, 4'b0010);
        rd(8'h00, 2'd0, 32'h0012_2211, "R2 lane 1 write");
        wr(8'h34, 32'h0000_0002);
        wr(8'h30, 32'h0000_0002);
        wr(8'h28, 32'h0000_0002);
        set_in(32'h2);
        rd(8'h40, 2'd1, 32'h0000_0002, "R5 rising edge latched");
        set_in(32'h0);
        rd(8'h40, 2'd1, 32'h0000_0002, "R5 latch sticky");
        chk_par(4'h2, "R7 parent1 from edge");
        rd(8'h40, 2'd0, 32'h0, "R9 other core filtered");

        // R6: acknowledge clears
        wr(8'h40, 32'h0000_0002);
        rd(8'h40, 2'd1, 32'h0, "R6 ack clears latch");

        // R5: falling edge, then R6 disable clears
        wr(8'h30, 32'h0);
        set_in(32'h2);
        set_in(32'h0);
        rd(8'h40, 2'd1, 32'h0000_0002, "R5 falling edge latched");
        wr(8'h2C, 32'h0000_0002);
        wr(8'h28, 32'h0000_0002);
        rd(8'h40, 2'd1, 32'h0, "R6 disable clears latch");

        // R11: edge while disabled is lost
        wr(8'h2C, 32'h0000_0002);
        wr(8'h30, 32'h0000_0002);
        set_in(32'h2);
        wr(8'h28, 32'h0000_0002);
        rd(8'h40, 2'd1, 32'h0, "R11 edge while disabled ignored");
        set_in(32'h0);

        // R10: edge in the same clock as acknowledge
        @(negedge clk);
        irq_in = 32'h2;
        bus_we = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h2; bus_be = 4'hF;
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h40, 2'd1, 32'h0000_0002, "R10 edge beats ack");
        wr(8'h40, 32'h0000_0002);
        rd(8'h40, 2'd1, 32'h0, "R6 later ack clears");
        set_in(32'h0);

        // R7/R8/R9: line3 route 0xC8, line4 route 0x04
        wr(8'h00, 32'hC800_0000, 4'b1000);
        wr(8'h04, 32'h0000_0004, 4'b0001);
        wr(8'h30, 32'h0000_001A);
        wr(8'h28, 32'h0000_0018);
        set_in(32'h8);
        chk_par(4'hC, "R7 two parents");
        rd(8'h40, 2'd3, 32'h0000_0008, "R9 core3 view");
        rd(8'h40, 2'd0, 32'h0, "R9 core0 view");
        set_in(32'h10);
        chk_par(4'h0, "R8 no parent selected");
        rd(8'h40, 2'd2, 32'h0000_0010, "R9 core2 view");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule